// File: doc/BRIEF.md
# Link Test Pattern Generator and Checker

This block exercises a 32-bit framed point-to-point link from both ends. On the sending side, a generator produces an endless run of frames. A ready input paces it, and the generator moves to its next word only when that word has been taken. On the receiving side, a checker rebuilds the same word sequence on its own. It compares every received word with the value it expects, and it keeps saturating counts of words, frames and mismatches. It also records the position and contents of the first bad word.

Three patterns can be selected. The first is a pseudo-random stream from a 32-bit LFSR. The second is a structured readout-style frame made of control words, a header that carries the frame number, a counting payload and a footer. The third is a single bit that walks across the word. Each frame has a configurable length, and the length and pattern are taken at the start of every frame. Generator and checker each hold an identical but separate sequencer. The bench or the system connects the transmit port to the receive port through the link under test.

Top module: `link_pattern_tester`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `tx_valid`, `err_seen` and every counter are zero.
- R2: With `mode`=00 or 11 (random), word j since reset is the LFSR state after j steps. The LFSR starts at 0xFFFFFFFF and steps as s' = {s[30:0], s[31]^s[21]^s[1]^s[0]} once per accepted word, whatever the mode.
- R3: With `mode`=01 (structured) and length L, word 0 is 0xC0DE0A0A, and words 1..9 are N, N+1, ..., N+8, where N is the frame number counted from 0 at reset. Words 10..L-5 are 0, 1, ..., L-15, and word L-4 is L-14. Words L-3 and L-2 are 0xF00DF00D and 0xE0F0E0F0, and word L-1 is 0xC0DE0E0E.
- R4: With `mode`=10 (walking), word i of a frame is 1 << (i mod 32).
- R5: The frame length is `frame_len` clamped to the range 16..MAX_LEN. It is sampled together with `mode` during reset and after the last word of each frame. `tx_last` is high exactly on word L-1.
- R6: The generator advances only when `tx_valid` and `tx_ready` are both high. On a stall, `tx_data` and `tx_last` stay unchanged.
- R7: Every cycle with `rx_valid` high adds one to `word_cnt`. It also adds one to `err_cnt` when `rx_data` differs from the expected word.
- R8: `frame_cnt` goes up by one for each received word that is the last word of its frame.
- R9: The first mismatch sets `err_seen` and latches `err_index` (the value of `word_cnt` before that word), `err_exp` and `err_got`. Later mismatches leave these unchanged.
- R10: `word_cnt`, `frame_cnt` and `err_cnt` stop at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Pattern select: 00/11 random, 01 structured, 10 walking |
| frame_len | input | LEN_W | Requested frame length in words |
| gen_en | input | 1 | Generator enable; drives `tx_valid` one cycle later |
| tx_ready | input | 1 | Link accepts the current word |
| tx_valid | output | 1 | Generator word valid |
| tx_data | output | 32 | Generator word |
| tx_last | output | 1 | Current word closes its frame |
| rx_valid | input | 1 | Received word valid |
| rx_data | input | 32 | Received word |
| word_cnt | output | CNT_W | Received words |
| frame_cnt | output | CNT_W | Received frames |
| err_cnt | output | CNT_W | Mismatched words |
| err_seen | output | 1 | At least one mismatch seen |
| err_index | output | CNT_W | Word index of first mismatch |
| err_exp | output | 32 | Expected value at first mismatch |
| err_got | output | 32 | Received value at first mismatch |

## Verification
The bench builds the block with MAX_LEN=300 and CNT_W=10. The smaller upper length limit lets the bench check a request of 500 clamped to a full 300-word frame, and a 256-word structured frame still fits. The 10-bit counters saturate at 1023, so about eleven hundred mismatched words are enough to show that the word and error counters hold at all ones. A transmit-to-receive loopback with a ready pattern that stalls the generator checks the checker against the generator. Single-bit flips on chosen words check the first-error latch.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    PAT_RAND   = 2'b00,
    PAT_FRAMED = 2'b01,
    PAT_WALK   = 2'b10,
    PAT_RAND2  = 2'b11
  } pat_e;

  localparam logic [31:0] CTRL_OPEN  = 32'hC0DE_0A0A;
  localparam logic [31:0] CTRL_CLOSE = 32'hC0DE_0E0E;
  localparam logic [31:0] TAIL_A     = 32'hF00D_F00D;
  localparam logic [31:0] TAIL_B     = 32'hE0F0_E0F0;
  localparam logic [31:0] LFSR_SEED  = 32'hFFFF_FFFF;
  localparam int          MIN_LEN    = 16;
  localparam int          HDR_WORDS  = 9;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/lpt_seq.sv
module lpt_seq
  import lpt_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic [31:0]      word_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] PAY_LO = LEN_W'(HDR_WORDS + 1);

  logic [LEN_W-1:0] idx, len_q, len_clamped;
  logic [31:0]      fnum, lfsr;
  pat_e             mode_q;

  always_comb begin
    if (len_i < LEN_LO)      len_clamped = LEN_LO;
    else if (len_i > LEN_HI) len_clamped = LEN_HI;
    else                     len_clamped = len_i;
  end

  assign last_o = (idx == len_q - LEN_W'(1));

  always_comb begin
    case (mode_q)
      PAT_FRAMED: begin
        if (idx == '0)                        word_o = CTRL_OPEN;
        else if (idx < PAY_LO)                word_o = fnum + 32'(idx) - 32'd1;
        else if (idx <= len_q - LEN_W'(5))    word_o = 32'(idx - PAY_LO);
        else if (idx == len_q - LEN_W'(4))    word_o = 32'(len_q - LEN_W'(14));
        else if (idx == len_q - LEN_W'(3))    word_o = TAIL_A;
        else if (idx == len_q - LEN_W'(2))    word_o = TAIL_B;
        else                                  word_o = CTRL_CLOSE;
      end
      PAT_WALK: word_o = 32'd1 << idx[4:0];
      default:  word_o = lfsr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      fnum   <= '0;
      lfsr   <= LFSR_SEED;
      mode_q <= pat_e'(mode_i);
      len_q  <= len_clamped;
    end else if (step_i) begin
      lfsr <= lfsr_step(lfsr);
      if (last_o) begin
        idx    <= '0;
        fnum   <= fnum + 32'd1;
        mode_q <= pat_e'(mode_i);
        len_q  <= len_clamped;
      end else begin
        idx <= idx + LEN_W'(1);
      end
    end
  end

  // R5
  idx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    idx < len_q && len_q >= LEN_LO && len_q <= LEN_HI);

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != 32'd0);
endmodule

// File: rtl/lpt_gen.sv
module lpt_gen
  import lpt_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             gen_en,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [31:0]      tx_data,
  output logic             tx_last
);
  logic step;

  always_ff @(posedge clk) begin
    if (rst) tx_valid <= 1'b0;
    else     tx_valid <= gen_en;
  end

  assign step = tx_valid & tx_ready;

  lpt_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .mode_i(mode), .len_i(frame_len),
    .step_i(step), .word_o(tx_data), .last_o(tx_last)
  );

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> ($stable(tx_data) && $stable(tx_last)));
endmodule

// File: rtl/lpt_chk.sv
module lpt_chk
  import lpt_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rx_valid,
  input  logic [31:0]      rx_data,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_seen,
  output logic [CNT_W-1:0] err_index,
  output logic [31:0]      err_exp,
  output logic [31:0]      err_got
);
  logic [31:0] exp_word;
  logic        exp_last, miss;

  lpt_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .mode_i(mode), .len_i(frame_len),
    .step_i(rx_valid), .word_o(exp_word), .last_o(exp_last)
  );

  assign miss = rx_valid && (rx_data != exp_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_cnt  <= '0;
      frame_cnt <= '0;
      err_cnt   <= '0;
      err_seen  <= 1'b0;
      err_index <= '0;
      err_exp   <= '0;
      err_got   <= '0;
    end else if (rx_valid) begin
      if (word_cnt != '1) word_cnt <= word_cnt + CNT_W'(1);
      if (exp_last && frame_cnt != '1) frame_cnt <= frame_cnt + CNT_W'(1);
      if (miss) begin
        if (err_cnt != '1) err_cnt <= err_cnt + CNT_W'(1);
        if (!err_seen) begin
          err_seen  <= 1'b1;
          err_index <= word_cnt;
          err_exp   <= exp_word;
          err_got   <= rx_data;
        end
      end
    end
  end

  // R7
  err_le_words_chk: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= word_cnt);

  // R9
  first_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err_seen) |-> ($stable(err_index) && $stable(err_exp) && $stable(err_got) && err_seen));

  // R10
  words_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(word_cnt) == '1 |-> word_cnt == '1);
endmodule

// File: rtl/link_pattern_tester.sv
module link_pattern_tester
  import lpt_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  parameter int CNT_W   = 48,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             gen_en,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [31:0]      tx_data,
  output logic             tx_last,
  input  logic             rx_valid,
  input  logic [31:0]      rx_data,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_seen,
  output logic [CNT_W-1:0] err_index,
  output logic [31:0]      err_exp,
  output logic [31:0]      err_got
);
  lpt_gen #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_gen (
    .clk(clk), .rst(rst), .mode(mode), .frame_len(frame_len),
    .gen_en(gen_en), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  lpt_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .frame_len(frame_len),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .word_cnt(word_cnt), .frame_cnt(frame_cnt), .err_cnt(err_cnt),
    .err_seen(err_seen), .err_index(err_index),
    .err_exp(err_exp), .err_got(err_got)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!tx_valid && !err_seen && word_cnt == '0 && err_cnt == '0));
endmodule

// File: tb/tb_link_pattern_tester.sv
module tb_link_pattern_tester;
  localparam int MAXL = 300;
  localparam int CW   = 10;
  localparam int LW   = $clog2(MAXL + 1);

  logic clk = 0, rst = 1, gen_en = 0, tx_ready = 0;
  logic [1:0] mode = 0;
  logic [LW-1:0] frame_len = 20;
  logic tx_valid, tx_last, rx_valid, err_seen;
  logic [31:0] tx_data, rx_data, err_exp, err_got;
  logic [CW-1:0] word_cnt, frame_cnt, err_cnt, err_index;
  logic loop_on = 1, man_valid = 0;
  logic [31:0] man_data = 0, flip = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_mode, m_len, m_idx, acc;
  logic [31:0] m_n, m_lf;

  always #2 clk = ~clk;

  assign rx_valid = loop_on ? (tx_valid & tx_ready) : man_valid;
  assign rx_data  = loop_on ? (tx_data ^ flip) : man_data;

  link_pattern_tester #(.MAX_LEN(MAXL), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .mode(mode), .frame_len(frame_len), .gen_en(gen_en),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .word_cnt(word_cnt), .frame_cnt(frame_cnt),
    .err_cnt(err_cnt), .err_seen(err_seen), .err_index(err_index),
    .err_exp(err_exp), .err_got(err_got)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    int tail;
    tail = m_len - m_idx;
    if (m_mode == 1) begin
      if (m_idx == 0) return 32'hC0DE0A0A;
      if (tail == 1)  return 32'hC0DE0E0E;
      if (tail == 2)  return 32'hE0F0E0F0;
      if (tail == 3)  return 32'hF00DF00D;
      if (tail == 4)  return 32'(m_len - 14);
      if (m_idx <= 9) return m_n + 32'(m_idx - 1);
      return 32'(m_idx - 10);
    end
    if (m_mode == 2) return 32'h1 << (m_idx % 32);
    return m_lf;
  endfunction

  function automatic string mtag();
    return (m_mode == 1) ? "R3" : (m_mode == 2) ? "R4" : "R2";
  endfunction

  task automatic do_reset(input int md, input int len);
    @(negedge clk);
    rst = 1; gen_en = 0; tx_ready = 0; loop_on = 1; man_valid = 0; flip = 0;
    mode = 2'(md); frame_len = LW'(len);
    repeat (3) @(negedge clk);
    rst = 0;
    m_mode = md; m_len = (len < 16) ? 16 : (len > MAXL) ? MAXL : len;
    m_idx = 0; m_n = 0; m_lf = 32'hFFFFFFFF; acc = 0;
  endtask

  // stall=1 -> ready low every third cycle; flips at given accepted indices
  task automatic stream(input int cycles, input bit stall, input int f1, input int f2);
    logic [31:0] pdata;
    bit pstall;
    pstall = 0; pdata = 0;
    gen_en = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pstall) check("R6 hold", {32'd0, tx_data}, {32'd0, pdata});
      if (tx_valid) begin
        check(mtag(), {32'd0, tx_data}, {32'd0, model_word()});
        check("R5 last", {63'd0, tx_last}, {63'd0, m_idx == m_len - 1});
      end
      tx_ready = stall ? ((i % 3) != 1) : 1'b1;
      flip = (tx_valid && tx_ready && (acc == f1 || acc == f2)) ? 32'h1 : 32'h0;
      pstall = tx_valid && !tx_ready; pdata = tx_data;
      if (tx_valid && tx_ready) begin
        acc++;
        m_lf = {m_lf[30:0], m_lf[31] ^ m_lf[21] ^ m_lf[1] ^ m_lf[0]};
        if (m_idx == m_len - 1) begin m_idx = 0; m_n++; end
        else m_idx++;
      end
    end
    @(negedge clk);
    gen_en = 0; tx_ready = 0; flip = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(0, 20);
    check("R1 valid", {63'd0, tx_valid}, 0);
    check("R1 words", {54'd0, word_cnt}, 0);
    check("R1 errs", {54'd0, err_cnt}, 0);
    check("R1 seen", {63'd0, err_seen}, 0);
  endtask

  task automatic t_random();
    do_reset(0, 20);
    stream(90, 1, -1, -1);
    check("R7 words", {54'd0, word_cnt}, 64'(acc));
    check("R7 errs", {54'd0, err_cnt}, 0);
    check("R8 frames", {54'd0, frame_cnt}, 64'(acc / 20));
  endtask

  task automatic t_struct(input int len);
    do_reset(1, len);
    stream(2 * len + 10, 1, -1, -1);
    check("R3 errs", {54'd0, err_cnt}, 0);
    check("R8 frames", {54'd0, frame_cnt}, 64'(acc / len));
  endtask

  task automatic t_walk();
    do_reset(2, 40);
    stream(100, 0, -1, -1);
    check("R4 errs", {54'd0, err_cnt}, 0);
  endtask

  task automatic t_clamp();
    do_reset(2, 5);
    stream(40, 0, -1, -1);
    check("R5 short frames", {54'd0, frame_cnt}, 64'(acc / 16));
    do_reset(2, 500);
    stream(310, 0, -1, -1);
    check("R5 long frames", {54'd0, frame_cnt}, 64'(acc / 300));
  endtask

  task automatic t_error();
    logic [31:0] lf;
    do_reset(0, 20);
    stream(30, 0, 4, 7);
    lf = 32'hFFFFFFFF;
    for (int k = 0; k < 4; k++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    check("R7 errs", {54'd0, err_cnt}, 2);
    check("R9 seen", {63'd0, err_seen}, 1);
    check("R9 index", {54'd0, err_index}, 4);
    check("R9 exp", {32'd0, err_exp}, {32'd0, lf});
    check("R9 got", {32'd0, err_got}, {32'd0, lf ^ 32'h1});
  endtask

  task automatic t_sat();
    do_reset(0, 20);
    loop_on = 0; man_data = 0;
    @(negedge clk); man_valid = 1;
    repeat (1100) @(negedge clk);
    man_valid = 0;
    @(negedge clk);
    check("R10 words", {54'd0, word_cnt}, 1023);
    check("R10 errs", {54'd0, err_cnt}, 1023);
    check("R9 index", {54'd0, err_index}, 0);
    check("R9 exp", {32'd0, err_exp}, 64'hFFFFFFFF);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_random();
    t_struct(16);
    t_struct(256);
    t_walk();
    t_clamp();
    t_error();
    t_sat();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule